// File: doc/BRIEF.md
# Command Packet Taskfile Sequencer

This block executes one command packet stored in a small byte-wide local memory. After a start pulse it reads the packet header and checks the valid flag. It then walks the embedded list of register entries and replays each entry that is not skipped onto a taskfile write port, in memory order. A packet that asks for a data phase has its scatter/gather table pointer handed to the data-transfer stage, and the block waits for that stage to report completion. At the end it writes the response flags back into byte 0 of the packet and returns to idle.

The register list is a sequence of two-byte entries, a value byte followed by an address byte, beginning at byte 16. The address byte carries the register select and two markers: one suppresses the write, the other ends the list. The header length byte bounds the walk, so a list without an end marker cannot run past the packet. Wide commands put their high-order bytes earlier in the list, and the block preserves that order because it replays the list exactly as stored.

The controller states are IDLE, HDR, CHECK, L_VAL, L_ADR, L_DEC, XFER_GO, XFER_WAIT and WB. Their transitions are as follows:
- IDLE to HDR on start.
- HDR to CHECK once the last header byte has been captured.
- CHECK to IDLE when the packet is rejected.
- CHECK to L_VAL when the list is non-empty.
- CHECK to XFER_GO or WB when the list is empty.
- L_VAL to L_ADR, and L_ADR to L_DEC, unconditionally.
- L_DEC back to L_VAL for the next entry.
- L_DEC to XFER_GO or WB at the end marker or at the length bound.
- XFER_GO to XFER_WAIT.
- XFER_WAIT to WB on transfer done.
- WB to IDLE.

Top module: `cps_seq`

## Requirements
- R1: A start pulse is accepted only in idle. A start pulse seen while a packet is in progress has no effect: the packet still produces exactly one write-back and no further activity follows.
- R2: If bit 0 (valid) of header byte 2 is clear, the block pulses pkt_reject for one cycle and returns to idle. It makes no taskfile write, no transfer hand-off and no write-back.
- R3: Register entries are read from byte 16 onward, with entry k occupying bytes 16+2k (value) and 17+2k (address). Each entry that is written puts address-byte bits 4:0 on tf_addr and the value on tf_data, with tf_we high for one cycle. Writes occur in list order, and bit 6 of the address byte has no effect.
- R4: An entry whose address byte has bit 5 set produces no taskfile write.
- R5: An entry whose address byte has bit 7 set is the last entry processed, whether or not it is skipped.
- R6: At most 4×L entries are processed, where L is header byte 3. The list ends at that bound even without an end marker, and L = 0 processes no entries.
- R7: If bit 2 (data phase) of byte 2 is set, then after the list xfer_start pulses for one cycle with prd_ptr equal to bytes 8..11 as a little-endian value (byte 8 least significant). The block then waits for xfer_done.
- R8: If bit 2 of byte 2 is clear, xfer_start never pulses and the write-back follows the list directly, with no error flag.
- R9: The write-back is a single write of byte 0 with bit 0 set. Bit 3 is also set if xfer_err was high together with xfer_done, and all other bits are zero.
- R10: cmd_irq pulses in the write-back cycle exactly when bit 3 (interrupt on completion) of byte 2 is set, and the block is idle afterwards.
- R11: During reset, tf_we, mem_we, xfer_start, pkt_reject and cmd_irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing the packet in memory |
| mem_addr | output | MEM_AW | Packet memory byte address |
| mem_we | output | 1 | Packet memory write enable |
| mem_wdata | output | 8 | Packet memory write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_addr |
| tf_we | output | 1 | Taskfile write strobe |
| tf_addr | output | 5 | Taskfile register select |
| tf_data | output | 8 | Taskfile write data |
| xfer_start | output | 1 | One-cycle hand-off to the data-transfer stage |
| prd_ptr | output | 32 | Scatter/gather table pointer from the header |
| xfer_done | input | 1 | Data transfer finished |
| xfer_err | input | 1 | Device error, sampled with xfer_done |
| pkt_reject | output | 1 | One-cycle pulse for a packet without the valid flag |
| cmd_irq | output | 1 | Completion pulse when interrupt-on-completion is set |

## Verification
The assertions rely on three properties of the inputs: the memory returns data exactly one cycle after the address, the packet bytes do not change while a packet is in progress, and the transfer stage answers with xfer_done only after xfer_start. The bench loads each packet through a separate load port while the block is idle. It raises xfer_done a few cycles after it sees the hand-off and leaves xfer_done low otherwise. Random packets mix the valid, data-phase and interrupt flags, skip and end markers, a set bit 6 and lengths of one to six. Directed packets cover a 48-bit command layout, a zero length, a list cut off by its length, an error return and a start pulse during a packet.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_CHECK,
        ST_L_VAL,
        ST_L_ADR,
        ST_L_DEC,
        ST_XFER_GO,
        ST_XFER_WAIT,
        ST_WB
    } cps_state_e;

    // Header byte offsets
    localparam logic [3:0] HOFS_CTL   = 4'd2;
    localparam logic [3:0] HOFS_LEN   = 4'd3;
    localparam logic [3:0] HOFS_PRD0  = 4'd8;
    localparam logic [3:0] HOFS_PRD1  = 4'd9;
    localparam logic [3:0] HOFS_PRD2  = 4'd10;
    localparam logic [3:0] HOFS_PRD3  = 4'd11;
    localparam logic [3:0] HOFS_LAST  = 4'd11;
    localparam int         LIST_BASE  = 16;

    // Control flag bits
    localparam int CTL_VALID = 0;
    localparam int CTL_DATA  = 2;
    localparam int CTL_IEN   = 3;

    // Entry address byte bits
    localparam int ENT_SKIP = 5;
    localparam int ENT_END  = 7;

    // Response flag bits
    localparam int RSP_DONE   = 0;
    localparam int RSP_DEVERR = 3;

    localparam int PTR_W = 32;
    localparam int IDX_W = 10;

endpackage

// File: rtl/cps_hdr_capture.sv
module cps_hdr_capture
    import cps_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [7:0]        rdata,
    output logic [MEM_AW-1:0] hdr_addr,
    output logic              hdr_done,
    output logic              ctl_valid,
    output logic              ctl_data,
    output logic              ctl_ien,
    output logic [7:0]        len,
    output logic [PTR_W-1:0]  prd
);

    logic [3:0] rd_ofs;
    logic [3:0] pend_ofs;
    logic       pend_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ofs    <= '0;
            pend_ofs  <= '0;
            pend_vld  <= 1'b0;
            ctl_valid <= 1'b0;
            ctl_data  <= 1'b0;
            ctl_ien   <= 1'b0;
            len       <= '0;
            prd       <= '0;
        end else begin
            if (load) begin
                rd_ofs   <= HOFS_CTL;
                pend_vld <= 1'b0;
            end else if (active && (rd_ofs <= HOFS_LAST)) begin
                pend_ofs <= rd_ofs;
                pend_vld <= 1'b1;
                rd_ofs   <= rd_ofs + 4'd1;
            end else begin
                pend_vld <= 1'b0;
            end

            if (pend_vld) begin
                unique case (pend_ofs)
                    HOFS_CTL: begin
                        ctl_valid <= rdata[CTL_VALID];
                        ctl_data  <= rdata[CTL_DATA];
                        ctl_ien   <= rdata[CTL_IEN];
                    end
                    HOFS_LEN:  len         <= rdata;
                    HOFS_PRD0: prd[7:0]    <= rdata;
                    HOFS_PRD1: prd[15:8]   <= rdata;
                    HOFS_PRD2: prd[23:16]  <= rdata;
                    HOFS_PRD3: prd[31:24]  <= rdata;
                    default: ;
                endcase
            end
        end
    end

    assign hdr_addr = MEM_AW'(rd_ofs);
    assign hdr_done = active && (rd_ofs == HOFS_LAST + 4'd1);

endmodule

// File: rtl/cps_entry_walk.sv
module cps_entry_walk
    import cps_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic              walking,
    input  logic [7:0]        len,
    output logic [MEM_AW-1:0] val_addr,
    output logic [MEM_AW-1:0] adr_addr,
    output logic              last_ent,
    output logic              list_empty
);

    logic [IDX_W-1:0] ent_idx;
    logic [IDX_W-1:0] ent_bound;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_idx <= '0;
        end else if (clear) begin
            ent_idx <= '0;
        end else if (advance) begin
            ent_idx <= ent_idx + IDX_W'(1);
        end
    end

    assign ent_bound  = {len, 2'b00};
    assign list_empty = (len == 8'd0);
    assign last_ent   = (ent_idx + IDX_W'(1)) == ent_bound;
    assign val_addr   = MEM_AW'(LIST_BASE) + MEM_AW'({ent_idx, 1'b0});
    assign adr_addr   = val_addr + MEM_AW'(1);

    AST_ENTRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        walking |-> (ent_idx < ent_bound)); // R6

endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
    import cps_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hdr_done,
    input  logic              ctl_valid,
    input  logic              ctl_data,
    input  logic              ctl_ien,
    input  logic              list_empty,
    input  logic              last_ent,
    input  logic [MEM_AW-1:0] hdr_addr,
    input  logic [MEM_AW-1:0] val_addr,
    input  logic [MEM_AW-1:0] adr_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              accept,
    output logic              hdr_active,
    output logic              advance,
    output logic              walking,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              tf_we,
    output logic [4:0]        tf_addr,
    output logic [7:0]        tf_data,
    output logic              xfer_start,
    output logic              pkt_reject,
    output logic              cmd_irq
);

    cps_state_e state, state_nx;
    logic [7:0] val_q;
    logic       err_q;
    logic       list_stop;
    cps_state_e post_list;

    assign list_stop = mem_rdata[ENT_END] || last_ent;
    assign post_list = ctl_data ? ST_XFER_GO : ST_WB;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_HDR;
            ST_HDR:       if (hdr_done) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (!ctl_valid)      state_nx = ST_IDLE;
                else if (list_empty) state_nx = post_list;
                else                 state_nx = ST_L_VAL;
            end
            ST_L_VAL:     state_nx = ST_L_ADR;
            ST_L_ADR:     state_nx = ST_L_DEC;
            ST_L_DEC:     state_nx = list_stop ? post_list : ST_L_VAL;
            ST_XFER_GO:   state_nx = ST_XFER_WAIT;
            ST_XFER_WAIT: if (xfer_done) state_nx = ST_WB;
            ST_WB:        state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (accept) err_q <= 1'b0;
            else if (state == ST_XFER_WAIT && xfer_done) err_q <= xfer_err;
            if (state == ST_L_ADR) val_q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        accept     = 1'b0;
        hdr_active = 1'b0;
        advance    = 1'b0;
        walking    = 1'b0;
        mem_addr   = '0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        tf_we      = 1'b0;
        tf_addr    = '0;
        tf_data    = '0;
        xfer_start = 1'b0;
        pkt_reject = 1'b0;
        cmd_irq    = 1'b0;
        unique case (state)
            ST_IDLE:  accept = start;
            ST_HDR: begin
                hdr_active = 1'b1;
                mem_addr   = hdr_addr;
            end
            ST_CHECK: pkt_reject = !ctl_valid;
            ST_L_VAL: begin
                walking  = 1'b1;
                mem_addr = val_addr;
            end
            ST_L_ADR: begin
                walking  = 1'b1;
                mem_addr = adr_addr;
            end
            ST_L_DEC: begin
                walking = 1'b1;
                tf_we   = !mem_rdata[ENT_SKIP];
                tf_addr = mem_rdata[4:0];
                tf_data = val_q;
                advance = !list_stop;
            end
            ST_XFER_GO:   xfer_start = 1'b1;
            ST_XFER_WAIT: ;
            ST_WB: begin
                mem_we                = 1'b1;
                mem_addr              = '0;
                mem_wdata[RSP_DONE]   = 1'b1;
                mem_wdata[RSP_DEVERR] = err_q;
                cmd_irq               = ctl_ien;
            end
            default: ;
        endcase
    end

    AST_TF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tf_we |-> ctl_valid); // R2
    AST_XFER_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R7
    AST_XFER_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ctl_data); // R8
    AST_WB_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == '0) && mem_wdata[RSP_DONE]); // R9
    AST_IRQ_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |-> mem_we && ctl_ien); // R10
    AST_WB_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we && !tf_we && !xfer_start); // R10
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_reject |=> !tf_we && !mem_we && !xfer_start); // R2

endmodule

// File: rtl/cps_seq.sv
module cps_seq
    import cps_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              tf_we,
    output logic [4:0]        tf_addr,
    output logic [7:0]        tf_data,
    output logic              xfer_start,
    output logic [31:0]       prd_ptr,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              pkt_reject,
    output logic              cmd_irq
);

    logic              accept, hdr_active, advance, walking;
    logic              hdr_done, ctl_valid, ctl_data, ctl_ien;
    logic              last_ent, list_empty;
    logic [7:0]        len;
    logic [MEM_AW-1:0] hdr_addr, val_addr, adr_addr;

    cps_hdr_capture #(.MEM_AW(MEM_AW)) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .active    (hdr_active),
        .rdata     (mem_rdata),
        .hdr_addr  (hdr_addr),
        .hdr_done  (hdr_done),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .ctl_ien   (ctl_ien),
        .len       (len),
        .prd       (prd_ptr)
    );

    cps_entry_walk #(.MEM_AW(MEM_AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .advance    (advance),
        .walking    (walking),
        .len        (len),
        .val_addr   (val_addr),
        .adr_addr   (adr_addr),
        .last_ent   (last_ent),
        .list_empty (list_empty)
    );

    cps_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .hdr_done   (hdr_done),
        .ctl_valid  (ctl_valid),
        .ctl_data   (ctl_data),
        .ctl_ien    (ctl_ien),
        .list_empty (list_empty),
        .last_ent   (last_ent),
        .hdr_addr   (hdr_addr),
        .val_addr   (val_addr),
        .adr_addr   (adr_addr),
        .mem_rdata  (mem_rdata),
        .xfer_done  (xfer_done),
        .xfer_err   (xfer_err),
        .accept     (accept),
        .hdr_active (hdr_active),
        .advance    (advance),
        .walking    (walking),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .tf_we      (tf_we),
        .tf_addr    (tf_addr),
        .tf_data    (tf_data),
        .xfer_start (xfer_start),
        .pkt_reject (pkt_reject),
        .cmd_irq    (cmd_irq)
    );

endmodule

// File: tb/cps_seq_tb.sv
`timescale 1ns/1ps
module cps_seq_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          tf_we;
    logic [4:0]    tf_addr;
    logic [7:0]    tf_data;
    logic          xfer_start;
    logic [31:0]   prd_ptr;
    logic          xfer_done = 1'b0;
    logic          xfer_err = 1'b0;
    logic          pkt_reject;
    logic          cmd_irq;

    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_a = '0;
    logic [7:0]    ld_d = '0;
    logic [7:0]    mem [0:255];

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (ld_we)       mem[ld_a]     <= ld_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    cps_seq #(.MEM_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tf_we(tf_we), .tf_addr(tf_addr),
        .tf_data(tf_data), .xfer_start(xfer_start), .prd_ptr(prd_ptr),
        .xfer_done(xfer_done), .xfer_err(xfer_err),
        .pkt_reject(pkt_reject), .cmd_irq(cmd_irq)
    );

    // Packet image and expected results
    logic [7:0]  pk [0:63];
    logic [12:0] exp_tf [0:63];
    int          exp_n;
    bit          exp_rej, exp_xfer, exp_irq;
    logic [31:0] exp_prd;
    logic [7:0]  exp_wb;

    logic [12:0] got_tf [0:63];
    int          got_n, xs_n, rej_n, irq_n, wb_n;
    logic [31:0] prd_got;
    logic [AW-1:0] wb_a;
    logic [7:0]  wb_d;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_ent(input int k, input logic [7:0] v, input logic [7:0] a);
        pk[16+2*k] = v;
        pk[17+2*k] = a;
    endtask

    task automatic clear_pk();
        for (int i = 0; i < 64; i++) pk[i] = 8'($urandom);
    endtask

    task automatic compute_exp(input bit err);
        int nent;
        logic [7:0] a;
        exp_n    = 0;
        exp_rej  = !pk[2][0];
        exp_xfer = pk[2][0] && pk[2][2];
        exp_irq  = pk[2][0] && pk[2][3];
        exp_prd  = {pk[11], pk[10], pk[9], pk[8]};
        exp_wb   = 8'h01 | ((exp_xfer && err) ? 8'h08 : 8'h00);
        nent     = int'(pk[3]) * 4;
        if (!exp_rej) begin
            for (int k = 0; k < nent && k < 24; k++) begin
                a = pk[17+2*k];
                if (!a[5]) begin
                    exp_tf[exp_n] = {a[4:0], pk[16+2*k]};
                    exp_n++;
                end
                if (a[7]) break;
            end
        end
    endtask

    task automatic load_pkt();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_a = AW'(i); ld_d = pk[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run_pkt(input bit err, input bit extra_start, input string tag);
        int resp, tail;
        bit fin;
        compute_exp(err);
        load_pkt();
        got_n = 0; xs_n = 0; rej_n = 0; irq_n = 0; wb_n = 0;
        prd_got = '0; wb_a = '0; wb_d = '0;
        resp = 0; tail = 0; fin = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (tf_we) begin
                if (got_n < 64) got_tf[got_n] = {tf_addr, tf_data};
                got_n++;
            end
            if (xfer_start) begin
                xs_n++; prd_got = prd_ptr; resp = 3 + int'($urandom % 5);
            end
            if (pkt_reject) rej_n++;
            if (cmd_irq) irq_n++;
            if (mem_we) begin
                wb_n++; wb_a = mem_addr; wb_d = mem_wdata;
            end
            start = (cyc == 0) || (extra_start && cyc == 6);
            xfer_done = 1'b0; xfer_err = 1'b0;
            if (resp > 0) begin
                resp--;
                if (resp == 0) begin
                    xfer_done = 1'b1; xfer_err = err;
                end
            end
            if (wb_n > 0 || rej_n > 0) tail++;
            if (tail == 20) begin fin = 1; break; end
        end
        start = 1'b0; xfer_done = 1'b0; xfer_err = 1'b0;
        chk({tag, " R1 finished"}, 32'(fin), 32'd1);
        chk({tag, " R2 reject"}, 32'(rej_n), 32'(exp_rej));
        chk({tag, " R3 write count"}, 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk({tag, " R3 R4 R5 entry"}, 32'(got_tf[i]), 32'(exp_tf[i]));
        chk({tag, " R7 R8 hand-off"}, 32'(xs_n), 32'(exp_xfer));
        if (exp_xfer) chk({tag, " R7 prd_ptr"}, prd_got, exp_prd);
        chk({tag, " R1 R9 write-back count"}, 32'(wb_n), exp_rej ? 32'd0 : 32'd1);
        if (!exp_rej) begin
            chk({tag, " R9 write-back addr"}, 32'(wb_a), 32'd0);
            chk({tag, " R9 write-back data"}, 32'(wb_d), 32'(exp_wb));
            chk({tag, " R9 byte 0 stored"}, 32'(mem[0]), 32'(exp_wb));
        end
        chk({tag, " R10 irq"}, 32'(irq_n), 32'(exp_irq));
    endtask

    task automatic build_wide(input logic [7:0] ctl);
        clear_pk();
        pk[2] = ctl; pk[3] = 8'd3;
        pk[8] = 8'h78; pk[9] = 8'h56; pk[10] = 8'h34; pk[11] = 8'h12;
        put_ent(0,  8'hE0, 8'h16);
        put_ent(1,  8'h00, 8'h12);
        put_ent(2,  8'h11, 8'h13);
        put_ent(3,  8'h22, 8'h14);
        put_ent(4,  8'h33, 8'h15);
        put_ent(5,  8'h08, 8'h12);
        put_ent(6,  8'h44, 8'h13);
        put_ent(7,  8'h55, 8'h14);
        put_ent(8,  8'h66, 8'h15);
        put_ent(9,  8'h00, 8'h0E);
        put_ent(10, 8'h20, 8'h00 | 8'h20);
        put_ent(11, 8'h35, 8'h17 | 8'h80);
    endtask

    function automatic logic [4:0] pick_reg();
        unique case ($urandom % 7)
            0: return 5'h0E;
            1: return 5'h12;
            2: return 5'h13;
            3: return 5'h14;
            4: return 5'h15;
            5: return 5'h16;
            default: return 5'h17;
        endcase
    endfunction

    task automatic build_random();
        int len, nent, endpos;
        clear_pk();
        len  = 1 + int'($urandom % 6);
        nent = len * 4;
        endpos = int'($urandom % (nent + 2));
        pk[2] = {4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'(($urandom % 8) != 0)};
        pk[3] = 8'(len);
        for (int k = 0; k < nent; k++)
            put_ent(k, 8'($urandom),
                    {1'(k == endpos), 1'($urandom), 1'(($urandom % 5) == 0), pick_reg()});
    endtask

    initial begin
        #(150000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset
        chk("R11 reset tf_we", 32'(tf_we), 32'd0);
        chk("R11 reset mem_we", 32'(mem_we), 32'd0);
        chk("R11 reset xfer_start", 32'(xfer_start), 32'd0);
        chk("R11 reset pkt_reject", 32'(pkt_reject), 32'd0);
        chk("R11 reset cmd_irq", 32'(cmd_irq), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 48-bit layout, data phase, irq, no error then error
        build_wide(8'h0D);
        run_pkt(1'b0, 1'b0, "wide");
        build_wide(8'h0D);
        run_pkt(1'b1, 1'b0, "wide-err R9");

        // R2: invalid packet
        build_wide(8'h0C);
        run_pkt(1'b0, 1'b0, "invalid R2");

        // R6: zero length, no data phase, irq
        clear_pk(); pk[2] = 8'h09; pk[3] = 8'd0;
        put_ent(0, 8'h77, 8'h17);
        run_pkt(1'b1, 1'b0, "len0 R6 R8");

        // R6: no end marker, list cut at 4 entries; entries 4.. not replayed
        clear_pk(); pk[2] = 8'h01; pk[3] = 8'd1;
        for (int k = 0; k < 8; k++) put_ent(k, 8'(8'h10 + k), 8'h13);
        run_pkt(1'b0, 1'b0, "bound R6");

        // R4 R5: skipped entry with end marker stops the list
        clear_pk(); pk[2] = 8'h05; pk[3] = 8'd2;
        put_ent(0, 8'hA1, 8'h12);
        put_ent(1, 8'hA2, 8'hA0);
        put_ent(2, 8'hA3, 8'h17);
        put_ent(3, 8'hA4, 8'h97);
        run_pkt(1'b0, 1'b0, "skip-end R4 R5");

        // R3: bit 6 has no effect on the register select
        clear_pk(); pk[2] = 8'h01; pk[3] = 8'd1;
        put_ent(0, 8'h5A, 8'h56);
        put_ent(1, 8'hC3, 8'hD7);
        run_pkt(1'b0, 1'b0, "bit6 R3");

        // R1: start during a packet is ignored
        build_wide(8'h05);
        run_pkt(1'b0, 1'b1, "busy-start R1");

        for (int n = 0; n < 40; n++) begin
            build_random();
            run_pkt(1'($urandom), 1'($urandom % 4 == 0), "random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule